// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Long Unit

This datapath unit takes two 32-bit source words and picks one signed 16-bit half from each. Each operand has its own select bit that chooses the upper or the lower half. The unit multiplies the two halves and adds the 32-bit signed product, sign-extended, to a 64-bit accumulator. The accumulator enters as two 32-bit words, low and high, and the sum leaves in the same split form.

The interface is a registered single-cycle one. When `in_valid` is high at a rising edge, the unit samples its operands and the result appears one cycle later with `out_valid`. A new operation can be issued on every cycle without stalls. The 64-bit addition wraps silently and raises no flag. No overflow can arise before that point, because a 16x16 signed product always fits in 32 bits.

Top module: `mac_half_long`

## Requirements
- R1: `sel_a_hi` = 1 takes `src_a[31:16]` as the first signed factor, and `sel_a_hi` = 0 takes `src_a[15:0]`. The unselected half of `src_a` has no effect on the result.
- R2: `sel_b_hi` = 1 takes `src_b[31:16]` as the second signed factor, and `sel_b_hi` = 0 takes `src_b[15:0]`. The unselected half of `src_b` has no effect on the result.
- R3: The two factors are multiplied as two's-complement 16-bit values into an exact 32-bit product. For example, -32768 x -32768 gives +2^30.
- R4: The product is sign-extended to 64 bits before it is added. A negative product added to a zero accumulator gives `res_hi` = 32'hFFFF_FFFF.
- R5: `{res_hi,res_lo}` equals (`{acc_hi_in,acc_lo_in}` + sign-extended product) mod 2^64. Results past the signed or unsigned 64-bit limits wrap, and no flag is raised.
- R6: While `rst_n` is low, and after its release until the first accepted operation, `out_valid` is 0.
- R7: `out_valid` is 1 in exactly the cycle after each edge that samples `in_valid` = 1. Back-to-back operations each produce their own independent result without a stall.
- R8: `res_lo` and `res_hi` keep their last value through every cycle in which `in_valid` was low at the preceding edge.
- R9: The accumulator is split with bits [31:0] in `acc_lo_in`/`res_lo` and bits [63:32] in `acc_hi_in`/`res_hi`. A carry out of the low word propagates into the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| in_valid | input | 1 | Operands are sampled at this edge |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| sel_a_hi | input | 1 | 1 selects the upper half of `src_a`, 0 the lower |
| sel_b_hi | input | 1 | 1 selects the upper half of `src_b`, 0 the lower |
| acc_lo_in | input | 32 | Accumulator bits [31:0] |
| acc_hi_in | input | 32 | Accumulator bits [63:32] |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32] |

## Verification
A wrong half selection or a lost sign extension corrupts the result word one cycle after the offending operation. A lost sign extension shows first in `res_hi`, which becomes zero where it should be all ones. A broken carry between the two accumulator words shows in `res_hi` only when the low word overflows, so the bench drives operands that sit exactly at that boundary. A wrong valid register or result enable shows within one cycle, either as an `out_valid` in the wrong cycle or as a result that changes during idle cycles. The bench therefore compares both output words and the valid flag against its model on every clock.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  // Operation mode formed as {sel_a_hi, sel_b_hi}
  typedef enum logic [1:0] {
    MODE_LO_LO = 2'b00,
    MODE_LO_HI = 2'b01,
    MODE_HI_LO = 2'b10,
    MODE_HI_HI = 2'b11
  } hsm_mode_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hsm_half_pick.sv
module hsm_half_pick #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0]        word_i,
  input  logic                     pick_hi_i,
  output logic signed [HALF_W-1:0] half_o
);
  always_comb begin
    if (pick_hi_i) half_o = $signed(word_i[WORD_W-1:HALF_W]);
    else           half_o = $signed(word_i[HALF_W-1:0]);
  end
endmodule

// File: rtl/hsm_mul.sv
module hsm_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic signed [HALF_W-1:0] fa_i,
  input  logic signed [HALF_W-1:0] fb_i,
  output logic [PROD_W-1:0]        prod_o
);
  logic signed [PROD_W-1:0] fa_ext;
  logic signed [PROD_W-1:0] fb_ext;

  always_comb begin
    fa_ext = $signed({{HALF_W{fa_i[HALF_W-1]}}, fa_i});
    fb_ext = $signed({{HALF_W{fb_i[HALF_W-1]}}, fb_i});
    prod_o = fa_ext * fb_ext;
  end
endmodule

// File: rtl/hsm_acc_add.sv
module hsm_acc_add #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] acc_lo_i,
  input  logic [WORD_W-1:0] acc_hi_i,
  input  logic [WORD_W-1:0] prod_i,
  output logic [WORD_W-1:0] sum_lo_o,
  output logic [WORD_W-1:0] sum_hi_o
);
  logic              lo_carry;
  logic [WORD_W-1:0] ext_word;

  always_comb begin
    {lo_carry, sum_lo_o} = {1'b0, acc_lo_i} + {1'b0, prod_i};
    ext_word             = {WORD_W{prod_i[WORD_W-1]}};
    sum_hi_o             = acc_hi_i + ext_word + {{(WORD_W-1){1'b0}}, lo_carry};
  end
endmodule

// File: rtl/mac_half_long.sv
module mac_half_long #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic [WORD_W-1:0] acc_lo_in,
  input  logic [WORD_W-1:0] acc_hi_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);
  import hsm_pkg::*;

  localparam int unsigned HALF_W = WORD_W / 2;

  hsm_mode_e                mode;
  logic [WORD_W-1:0]        op_word [NUM_OPS];
  logic                     op_sel  [NUM_OPS];
  logic signed [HALF_W-1:0] op_half [NUM_OPS];
  logic [WORD_W-1:0]        prod_w;
  logic [WORD_W-1:0]        sum_lo, sum_hi;

  logic              vld_d, vld_q;
  logic              res_en;
  logic [WORD_W-1:0] lo_d, lo_q, hi_d, hi_q;

  always_comb begin
    mode       = hsm_mode_e'({sel_a_hi, sel_b_hi});
    op_word[0] = src_a;
    op_word[1] = src_b;
    op_sel[0]  = mode[1];
    op_sel[1]  = mode[0];
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_pick
    hsm_half_pick #(.WORD_W(WORD_W)) u_pick (
      .word_i   (op_word[g]),
      .pick_hi_i(op_sel[g]),
      .half_o   (op_half[g])
    );
  end

  hsm_mul #(.HALF_W(HALF_W)) u_mul (
    .fa_i  (op_half[0]),
    .fb_i  (op_half[1]),
    .prod_o(prod_w)
  );

  hsm_acc_add #(.WORD_W(WORD_W)) u_add (
    .acc_lo_i(acc_lo_in),
    .acc_hi_i(acc_hi_in),
    .prod_i  (prod_w),
    .sum_lo_o(sum_lo),
    .sum_hi_o(sum_hi)
  );

  // Next-state logic
  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    lo_d   = res_en ? sum_lo : lo_q;
    hi_d   = res_en ? sum_hi : hi_q;
  end

  // Control register: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Datapath registers: no reset, held through the enable path
  always_ff @(posedge clk) begin
    lo_q <= lo_d;
    hi_q <= hi_d;
  end

  assign out_valid = vld_q;
  assign res_lo    = lo_q;
  assign res_hi    = hi_q;
endmodule

// File: rtl/hsm_checker.sv
module hsm_checker #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] src_a,
  input logic [WORD_W-1:0] src_b,
  input logic              sel_a_hi,
  input logic              sel_b_hi,
  input logic [WORD_W-1:0] acc_lo_in,
  input logic [WORD_W-1:0] acc_hi_in,
  input logic              out_valid,
  input logic [WORD_W-1:0] res_lo,
  input logic [WORD_W-1:0] res_hi,
  input logic [WORD_W-1:0] prod
);
  logic signed [HALF_W-1:0]   ha, hb;
  logic signed [2*WORD_W-1:0] prod64;
  logic [2*WORD_W-1:0]        want;
  logic [WORD_W-1:0]          prod_max, prod_min;

  always_comb begin
    ha       = sel_a_hi ? $signed(src_a[WORD_W-1:HALF_W]) : $signed(src_a[HALF_W-1:0]);
    hb       = sel_b_hi ? $signed(src_b[WORD_W-1:HALF_W]) : $signed(src_b[HALF_W-1:0]);
    prod64   = (2*WORD_W)'(ha) * (2*WORD_W)'(hb);
    want     = {acc_hi_in, acc_lo_in} + prod64;
    prod_max = WORD_W'(1) << (WORD_W - 2);
    prod_min = -(prod_max - (WORD_W'(1) << (HALF_W - 1)));
  end

  // R5 (with R1, R2, R4, R9): sampled operation appears on the outputs one cycle later
  a_r5_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ({res_hi, res_lo} == $past(want)));

  // R7: valid follows the accepted operation
  a_r7_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: results held while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({res_hi, res_lo}));

  // R3: product stays within the 16x16 signed range
  a_r3_prod_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($signed(prod) <= $signed(prod_max) && $signed(prod) >= $signed(prod_min)));
endmodule

bind mac_half_long hsm_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .src_a    (src_a),
  .src_b    (src_b),
  .sel_a_hi (sel_a_hi),
  .sel_b_hi (sel_b_hi),
  .acc_lo_in(acc_lo_in),
  .acc_hi_in(acc_hi_in),
  .out_valid(out_valid),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .prod     (prod_w)
);

// File: tb/tb_mac_half_long.sv
`timescale 1ns/1ps
module tb_mac_half_long;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_a, src_b, acc_lo_in, acc_hi_in;
  logic        sel_a_hi, sel_b_hi;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mac_half_long dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
    .acc_lo_in(acc_lo_in), .acc_hi_in(acc_hi_in),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  // Behavioural reference model
  string       cur_tag = "R6";
  string       exp_tag = "R6";
  bit          exp_v   = 1'b0;
  bit          have_res = 1'b0;
  logic [63:0] exp_res = '0;

  function automatic logic [63:0] ref_op(logic [31:0] a, logic [31:0] b, bit sa, bit sb,
                                         logic [31:0] lo, logic [31:0] hi);
    shortint     x, y;
    longint      p;
    x = sa ? shortint'(a[31:16]) : shortint'(a[15:0]);
    y = sb ? shortint'(b[31:16]) : shortint'(b[15:0]);
    p = longint'(x) * longint'(y);
    return {hi, lo} + 64'(p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v   <= 1'b0;
      exp_tag <= "R6";
    end else if (in_valid) begin
      exp_v    <= 1'b1;
      exp_res  <= ref_op(src_a, src_b, sel_a_hi, sel_b_hi, acc_lo_in, acc_hi_in);
      have_res <= 1'b1;
      exp_tag  <= cur_tag;
    end else begin
      exp_v   <= 1'b0;
      exp_tag <= have_res ? "R8" : "R6";
    end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(exp_tag, "out_valid", 64'(out_valid), 64'(exp_v));
      if (have_res) check(exp_tag, "result", {res_hi, res_lo}, exp_res);
    end
  end

  task automatic op(logic [31:0] a, logic [31:0] b, bit sa, bit sb,
                    logic [63:0] acc, string tag);
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; sel_a_hi = sa; sel_b_hi = sb;
    acc_lo_in = acc[31:0]; acc_hi_in = acc[63:32]; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = $urandom; src_b = $urandom; acc_lo_in = $urandom; acc_hi_in = $urandom;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b1; in_valid = 1'b0;
    src_a = '0; src_b = '0; sel_a_hi = 0; sel_b_hi = 0; acc_lo_in = '0; acc_hi_in = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R6: held low during reset (also checked each cycle)
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R6 out_valid in reset: actual %b expected 0", out_valid);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    idle(3);
    // R1/R2: four modes, unselected halves carry distracting values
    op(32'h7FFF_0003, 32'h8000_FFFB, 0, 0, 64'd100, "R1");
    op(32'h7FFF_0003, 32'h8000_FFFB, 0, 1, 64'd100, "R2");
    op(32'h7FFF_0003, 32'h8000_FFFB, 1, 0, 64'd100, "R1");
    op(32'h7FFF_0003, 32'h8000_FFFB, 1, 1, 64'd100, "R2");
    // R1: unselected half of src_a changes, result unchanged
    op(32'h1234_0005, 32'h0000_0007, 0, 0, 64'd0, "R1");
    op(32'hFEDC_0005, 32'h0000_0007, 0, 0, 64'd0, "R1");
    // R2: unselected half of src_b changes
    op(32'h0000_0009, 32'h0004_AAAA, 0, 1, 64'd0, "R2");
    op(32'h0000_0009, 32'h0004_5555, 0, 1, 64'd0, "R2");
    // R3: extreme factors
    op(32'h8000_0000, 32'h8000_0000, 1, 1, 64'd0, "R3");
    op(32'h0000_8000, 32'h0000_7FFF, 0, 0, 64'd0, "R3");
    // R4: negative product into zero accumulator
    op(32'h0000_FFFF, 32'h0000_0001, 0, 0, 64'd0, "R4");
    // R5: wrap past signed and unsigned limits
    op(32'h0000_0001, 32'h0000_0001, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, "R5");
    op(32'h0000_0001, 32'h0000_0001, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    op(32'h0000_FFFF, 32'h0000_0001, 0, 0, 64'h8000_0000_0000_0000, "R5");
    // R9: carry from low into high word, and borrow
    op(32'h0000_0002, 32'h0000_0001, 0, 0, 64'h0000_0005_FFFF_FFFF, "R9");
    op(32'h0000_FFFF, 32'h0000_0001, 0, 0, 64'h0000_0005_0000_0000, "R9");
    idle(4);  // R8: hold through idle cycles
    // R7: long back-to-back random stream
    for (int i = 0; i < 300; i++)
      op($urandom, $urandom, 1'($urandom), 1'($urandom), {32'($urandom), 32'($urandom)}, "R7");
    idle(2);
    for (int i = 0; i < 100; i++) begin
      op($urandom, $urandom, 1'($urandom), 1'($urandom), {32'($urandom), 32'($urandom)}, "R7");
      idle(1 + ($urandom % 3));
    end
    idle(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule